// File: doc/BRIEF.md
# Four-State Cache Line Coherence Controller

This block keeps the coherence status of every line in a small cache bank. Each line holds a two-bit code for one of four states: Modified, Exclusive, Shared or Invalid. Two kinds of event reach it. The local processor performs reads and writes. Other bus masters generate reads and writes that the snoop logic has already matched against this cache's tags. For each event the block decides whether a local write must be placed on the system bus. It also decides whether a dirty line must be written back, or a clean line dropped from the data array. It works out the state the line takes next and stores it on the following clock edge.

The local port supplies a line index, a read/write flag and the tag-match result from the tag array. A hit counts only when the line is also valid. The snoop port supplies a line index and a read/write flag. The shared-response input tells a read fill whether any other cache answered that it holds the block. All request outputs are combinational and belong to the cycle in which the event is presented. The `new_state` output always shows the value that the line addressed by the local port will hold after the next edge. With the local port idle, the same output serves to observe a line's current state.

Top module: `coh_line_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, every line reads as Invalid.
- R2: State codes are Invalid = 2'b00, Shared = 2'b01, Exclusive = 2'b10, Modified = 2'b11 on `new_state`.
- R3: A local read that hits a valid line leaves its state unchanged and raises neither `bus_wr_req` nor `victim_wb_req`.
- R4: A local write hit on a Modified or Exclusive line does not raise `bus_wr_req`, and the line becomes Modified.
- R5: A local write hit on a Shared line raises `bus_wr_req` in the same cycle, and the line becomes Modified.
- R6: A local write that misses (tag mismatch or Invalid line) raises `bus_wr_req` and leaves the line's state unchanged.
- R7: A local read miss fills the line as Exclusive when `shared_in` is 0 and as Shared when it is 1. It raises `victim_wb_req` only if the replaced line was Modified.
- R8: A snooped read moves Modified to Shared with `snoop_wb_req` high, and moves Exclusive to Shared. It leaves Shared and Invalid unchanged, with no request.
- R9: A snooped write sets any valid line to Invalid. It raises `snoop_wb_req` if the line was Modified and `inval_req` if the line was Exclusive or Shared. An Invalid line gives no request.
- R10: When a snoop and a local access address the same line in one cycle, the snoop wins. The local access is dropped: no `bus_wr_req` and no `victim_wb_req`, and the line takes the snoop's result.
- R11: A snoop and a local access to different lines in one cycle are both applied at the same edge.
- R12: `new_state` in a cycle equals the state the locally addressed line holds after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Local access present this cycle |
| acc_idx | input | IDX_W | Line index of the local access |
| acc_write | input | 1 | 1 = local write, 0 = local read |
| acc_hit | input | 1 | Tag match reported by the tag array |
| snp_valid | input | 1 | Snooped transaction hitting this cache |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| snp_write | input | 1 | 1 = snooped write, 0 = snooped read |
| shared_in | input | 1 | Another cache holds the block being filled |
| bus_wr_req | output | 1 | Local write must be issued on the bus |
| victim_wb_req | output | 1 | Modified line being replaced by a read fill needs write-back |
| snoop_wb_req | output | 1 | Modified line hit by a snoop needs write-back |
| inval_req | output | 1 | Clean line dropped by a snooped write |
| new_state | output | 2 | Next state of the line at `acc_idx` |

## Verification
The assertions rely on three assumptions about the inputs. Snoop indices come from a tag match that has already been made. `acc_hit` is a plain tag compare, which the block combines with validity itself. Every input holds a defined value from time zero, because the next-state check reads the line chosen by `acc_idx` one cycle back. The stimulus follows these rules. It changes inputs only on the falling edge and returns to an idle pattern between operations. It brings each line into a chosen start state through legal event sequences: a snooped write to clear the line, a read fill to validate it, and a write hit to dirty it. It does not preload the state.

// File: rtl/coh_pkg.sv
package coh_pkg;

   // Two-bit line status; the encoding is visible on new_state.
   typedef enum logic [1:0] {
      LS_INV = 2'b00,
      LS_SHR = 2'b01,
      LS_EXC = 2'b10,
      LS_MOD = 2'b11
   } line_st_t;

   function automatic logic st_valid(input line_st_t s);
      return s != LS_INV;
   endfunction

endpackage

// File: rtl/coh_local_rules.sv
module coh_local_rules
   import coh_pkg::*;
(
   input  logic     acc_en,
   input  logic     acc_write,
   input  logic     acc_hit,
   input  logic     shared_in,
   input  line_st_t cur,
   output line_st_t nxt,
   output logic     bus_wr,
   output logic     victim_wb
);

   logic real_hit;
   assign real_hit = acc_hit && st_valid(cur);

   always_comb begin
      nxt       = cur;
      bus_wr    = 1'b0;
      victim_wb = 1'b0;
      if (acc_en) begin
         if (acc_write) begin
            if (real_hit) begin
               // clean-exclusive or dirty lines write silently; shared must broadcast
               bus_wr = (cur == LS_SHR);
               nxt    = LS_MOD;
            end else begin
               // write miss: goes straight to the bus, no allocation
               bus_wr = 1'b1;
            end
         end else if (!real_hit) begin
            nxt       = shared_in ? LS_SHR : LS_EXC;
            victim_wb = (cur == LS_MOD);
         end
      end
   end

endmodule

// File: rtl/coh_snoop_rules.sv
module coh_snoop_rules
   import coh_pkg::*;
(
   input  logic     snp_en,
   input  logic     snp_write,
   input  line_st_t cur,
   output line_st_t nxt,
   output logic     wb,
   output logic     inval
);

   always_comb begin
      nxt   = cur;
      wb    = 1'b0;
      inval = 1'b0;
      if (snp_en && st_valid(cur)) begin
         wb = (cur == LS_MOD);
         if (snp_write) begin
            nxt   = LS_INV;
            inval = (cur != LS_MOD);
         end else begin
            nxt = LS_SHR;
         end
      end
   end

endmodule

// File: rtl/coh_line_bank.sv
module coh_line_bank
   import coh_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       loc_we,
   input  logic [IDX_W-1:0]           loc_idx,
   input  line_st_t                   loc_nxt,
   input  logic                       snp_we,
   input  logic [IDX_W-1:0]           snp_idx,
   input  line_st_t                   snp_nxt,
   output line_st_t [NUM_LINES-1:0]   lines_o
);

   generate
      for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
         line_st_t st_q;
         line_st_t st_d;

         // snoop result overrides a local update to the same line
         always_comb begin
            st_d = st_q;
            if (snp_we && (snp_idx == IDX_W'(g)))
               st_d = snp_nxt;
            else if (loc_we && (loc_idx == IDX_W'(g)))
               st_d = loc_nxt;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= LS_INV;
            else        st_q <= st_d;
         end

         assign lines_o[g] = st_q;
      end
   endgenerate

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import coh_pkg::*;
#(
   parameter  int NUM_LINES = 8,
   localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic             acc_write,
   input  logic             acc_hit,
   input  logic             snp_valid,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic             snp_write,
   input  logic             shared_in,
   output logic             bus_wr_req,
   output logic             victim_wb_req,
   output logic             snoop_wb_req,
   output logic             inval_req,
   output logic [1:0]       new_state
);

   generate
      if (NUM_LINES < 2) begin : g_bad_lines
         $error("coh_line_ctrl: NUM_LINES must be at least 2");
      end
      if ((1 << IDX_W) < NUM_LINES) begin : g_bad_idx
         $error("coh_line_ctrl: index width too small");
      end
   endgenerate

   line_st_t [NUM_LINES-1:0] lines;
   line_st_t cur_loc, cur_snp, l_nxt, s_nxt;
   logic     same_line, clash, loc_en;

   assign cur_loc   = lines[acc_idx];
   assign cur_snp   = lines[snp_idx];
   assign same_line = snp_valid && (snp_idx == acc_idx);
   assign clash     = acc_valid && same_line;
   assign loc_en    = acc_valid && !clash;

   coh_local_rules u_loc (
      .acc_en    (loc_en),
      .acc_write (acc_write),
      .acc_hit   (acc_hit),
      .shared_in (shared_in),
      .cur       (cur_loc),
      .nxt       (l_nxt),
      .bus_wr    (bus_wr_req),
      .victim_wb (victim_wb_req)
   );

   coh_snoop_rules u_snp (
      .snp_en    (snp_valid),
      .snp_write (snp_write),
      .cur       (cur_snp),
      .nxt       (s_nxt),
      .wb        (snoop_wb_req),
      .inval     (inval_req)
   );

   coh_line_bank #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .loc_we  (loc_en),
      .loc_idx (acc_idx),
      .loc_nxt (l_nxt),
      .snp_we  (snp_valid),
      .snp_idx (snp_idx),
      .snp_nxt (s_nxt),
      .lines_o (lines)
   );

   assign new_state = same_line ? s_nxt : l_nxt;

   // R12: previewed state is what the line holds after the edge
   p_preview_matches_r12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lines[$past(acc_idx)] == line_st_t'($past(new_state))));

   // R8/R9: a snoop write-back never leaves the line dirty
   p_snoop_wb_cleans_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_wb_req |=> (lines[$past(snp_idx)] != LS_MOD));

   // R9: a snooped write always ends with the line invalid
   p_snoop_wr_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_write) |=> (lines[$past(snp_idx)] == LS_INV));

   // R10: a local access colliding with a snoop raises no local request
   p_clash_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clash |-> (!bus_wr_req && !victim_wb_req));

   // R4: private lines write without bus traffic
   p_private_write_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_en && acc_write && acc_hit && (cur_loc == LS_EXC || cur_loc == LS_MOD))
      |-> !bus_wr_req);

   // R4/R5: every write hit ends Modified
   p_write_hit_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_en && acc_write && acc_hit && cur_loc != LS_INV)
      |=> (lines[$past(acc_idx)] == LS_MOD));

   // R7: a read fill yields a valid clean line
   p_fill_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_en && !acc_write && (!acc_hit || cur_loc == LS_INV))
      |=> (lines[$past(acc_idx)] == LS_EXC || lines[$past(acc_idx)] == LS_SHR));

endmodule

// File: tb/sim_coh_line_ctrl.sv
module sim_coh_line_ctrl;

   localparam int N  = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 0, acc_write = 0, acc_hit = 0;
   logic snp_valid = 0, snp_write = 0, shared_in = 0;
   logic [IW-1:0] acc_idx = '0, snp_idx = '0;
   logic bus_wr_req, victim_wb_req, snoop_wb_req, inval_req;
   logic [1:0] new_state;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   coh_line_ctrl #(.NUM_LINES(N)) u0 (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_write(acc_write), .acc_hit(acc_hit),
      .snp_valid(snp_valid), .snp_idx(snp_idx), .snp_write(snp_write),
      .shared_in(shared_in),
      .bus_wr_req(bus_wr_req), .victim_wb_req(victim_wb_req),
      .snoop_wb_req(snoop_wb_req), .inval_req(inval_req),
      .new_state(new_state)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drv(input logic lv, input int li, input logic lw, input logic lh,
                      input logic sh, input logic sv, input int si, input logic sw);
      acc_valid = lv; acc_idx = IW'(li); acc_write = lw; acc_hit = lh;
      shared_in = sh; snp_valid = sv; snp_idx = IW'(si); snp_write = sw;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic peek(input int idx);
      drv(0, idx, 0, 0, 0, 0, 0, 0);
      #1;
   endtask

   // bring line idx to state st (0=I,1=S,2=E,3=M) through legal events
   task automatic go_to(input int idx, input int st);
      drv(0, idx, 0, 0, 0, 1, idx, 1); step();
      if (st != 0) begin
         drv(1, idx, 0, 0, (st == 1), 0, 0, 0); step();
      end
      if (st == 3) begin
         drv(1, idx, 1, 1, 0, 0, 0, 0); step();
      end
      drv(0, idx, 0, 0, 0, 0, 0, 0);
   endtask

   // expected {nxt[1:0], bus, victim} for a local access
   function automatic logic [3:0] exp_loc(input int st, input bit w, input bit h, input bit sh);
      bit hit = h && (st != 0);
      if (w) begin
         if (hit) return {2'b11, (st == 1) ? 1'b1 : 1'b0, 1'b0};
         return {2'(st), 2'b10};
      end
      if (hit) return {2'(st), 2'b00};
      return {sh ? 2'b01 : 2'b10, 1'b0, (st == 3) ? 1'b1 : 1'b0};
   endfunction

   // expected {nxt[1:0], wb, inval} for a snoop
   function automatic logic [3:0] exp_snp(input int st, input bit w);
      if (st == 0) return 4'b0000;
      if (w) return {2'b00, (st == 3) ? 1'b1 : 1'b0, (st != 3) ? 1'b1 : 1'b0};
      return {2'b01, (st == 3) ? 1'b1 : 1'b0, 1'b0};
   endfunction

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [3:0] e;
      string tg;
      // R1: reset state of every line, then reset released
      #1;
      for (int i = 0; i < N; i++) begin
         peek(i);
         chk("R1 during reset", new_state, 0);
      end
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         peek(i);
         chk("R1 after reset", new_state, 0);
      end

      // local access sweep: every start state x every access kind (R2 codes)
      for (int st = 0; st < 4; st++) begin
         for (int op = 0; op < 5; op++) begin
            int idx = (st * 5 + op) % N;
            bit w  = (op >= 3);
            bit h  = (op == 0 || op == 3);
            bit sh = (op == 2);
            if (op == 0)      tg = "R3";
            else if (op <= 2) tg = "R7";
            else if (op == 4) tg = "R6";
            else if (st == 1) tg = "R5";
            else              tg = "R4";
            go_to(idx, st);
            e = exp_loc(st, w, h, sh);
            drv(1, idx, w, h, sh, 0, 0, 0);
            #1;
            chk({tg, " bus_wr_req"}, bus_wr_req, e[1]);
            chk({tg, " victim_wb_req"}, victim_wb_req, e[0]);
            chk({tg, " R12 preview"}, new_state, e[3:2]);
            step();
            peek(idx);
            chk({tg, " R2 stored state"}, new_state, e[3:2]);
         end
      end

      // snoop sweep: every start state x read/write
      for (int st = 0; st < 4; st++) begin
         for (int w = 0; w < 2; w++) begin
            int idx = (st * 2 + w) % N;
            tg = (w != 0) ? "R9" : "R8";
            go_to(idx, st);
            e = exp_snp(st, w != 0);
            drv(0, idx, 0, 0, 0, 1, idx, w != 0);
            #1;
            chk({tg, " snoop_wb_req"}, snoop_wb_req, e[1]);
            chk({tg, " inval_req"}, inval_req, e[0]);
            chk({tg, " R12 preview"}, new_state, e[3:2]);
            step();
            peek(idx);
            chk({tg, " stored state"}, new_state, e[3:2]);
         end
      end

      // R10: same-line collision, snoop write vs local write hit
      for (int st = 1; st < 4; st++) begin
         go_to(5, st);
         drv(1, 5, 1, 1, 0, 1, 5, 1);
         #1;
         chk("R10 bus_wr_req dropped", bus_wr_req, 0);
         chk("R10 new_state", new_state, 0);
         step();
         peek(5);
         chk("R10 stored state", new_state, 0);
      end
      // R10: snoop read on Modified vs local read miss
      go_to(6, 3);
      drv(1, 6, 0, 0, 0, 1, 6, 0);
      #1;
      chk("R10 victim_wb_req dropped", victim_wb_req, 0);
      chk("R10 snoop_wb_req", snoop_wb_req, 1);
      step();
      peek(6);
      chk("R10 stored shared", new_state, 1);

      // R11: different lines in the same cycle
      go_to(1, 3);
      go_to(2, 0);
      drv(1, 2, 0, 0, 0, 1, 1, 0);
      #1;
      chk("R11 snoop_wb_req", snoop_wb_req, 1);
      chk("R11 victim_wb_req", victim_wb_req, 0);
      step();
      peek(1);
      chk("R11 snooped line", new_state, 1);
      peek(2);
      chk("R11 filled line", new_state, 2);
      go_to(3, 1);
      go_to(4, 2);
      drv(1, 4, 1, 1, 0, 1, 3, 1);
      #1;
      chk("R11 silent write", bus_wr_req, 0);
      chk("R11 inval_req", inval_req, 1);
      step();
      peek(3);
      chk("R11 invalidated line", new_state, 0);
      peek(4);
      chk("R11 written line", new_state, 3);

      // R1: reset mid-run clears dirty lines
      go_to(7, 3);
      rst_n = 1'b0;
      #1;
      peek(7);
      chk("R1 reset clears dirty", new_state, 0);
      @(negedge clk); rst_n = 1'b1;
      step();
      peek(7);
      chk("R1 stays invalid", new_state, 0);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule